// File: doc/BRIEF.md
# Tagged Conversion Result Queue with Status Word

This block sits between an analog-to-digital converter and a host register interface. The converter side offers a 4-bit source tag and a 12-bit result on a valid/ready stream. Each accepted pair is stored as one entry in a first-in first-out queue (default depth 16). The host pulls entries with a read request. The response comes back one cycle later as a 16-bit word with the tag in the top nibble.

A 16-bit status word is always visible. It reports whether the queue is empty, whether the converter is busy, whether the arithmetic unit is busy, and whether a result was lost. The arithmetic-unit busy flag is also forced high for a 134 µs initialization window after reset. The window length is derived from a clock-frequency parameter.

A host read against an empty queue returns the status word instead of data and leaves the queue untouched. A clear command empties the queue and drops the loss flag.

On the input stream, `in_ready` is low only while the queue holds its full depth. The converter cannot stall, so it may keep `in_valid` asserted regardless. Any beat presented while `in_ready` is low is discarded and recorded in the overflow flag. The read side has no back-pressure: every request is answered on the next cycle.

Top module: `conv_tag_fifo`

## Requirements
- R1: `in_ready` is 1 exactly when the queue holds fewer than DEPTH entries. A beat is stored when `in_valid` and `in_ready` are both 1 at a clock edge and `clr_fifo` is 0.
- R2: Every `rd_req` cycle gives `rd_ack` = 1 in the following cycle. When the queue was not empty, `rd_word` then holds the oldest entry, packed as tag in bits 15:12 and result in bits 11:0, and that entry is removed.
- R3: A read while the queue is empty returns the status word as it stood in the request cycle, and removes nothing.
- R4: The status word is laid out as follows: bit 0 is the empty flag (1 = no entries held), bit 1 is converter busy, bit 2 is arithmetic busy, and bit 3 is overflow. Bits 15:4 read as 0.
- R5: A beat offered while `in_ready` is 0 leaves the stored entries unchanged and sets the overflow bit. The overflow bit stays set until a clear or a reset.
- R6: The converter-busy bit equals the OR of `conv_active`, `alarm_active` and `in_valid` sampled at the previous clock edge.
- R7: After reset is released, the arithmetic-busy bit is forced to 1 for the first WIN clock edges, where WIN = ceil(134 × CLK_HZ / 1e6). Outside that window the bit equals `alu_active` sampled at the previous edge.
- R8: A `clr_fifo` cycle empties the queue and clears the overflow bit. A push offered in the same cycle is discarded, and so is any overflow it would have caused.
- R9: After reset the queue is empty, the overflow bit is 0, `rd_ack` is 0 and `in_ready` is 1.
- R10: The queue holds at most DEPTH entries, and it accepts exactly DEPTH entries before `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Converter result offered |
| in_ready | output | 1 | Queue has room |
| in_tag | input | 4 | Source channel tag |
| in_result | input | 12 | Conversion result |
| conv_active | input | 1 | Converter is converting |
| alarm_active | input | 1 | Alarm comparison running |
| alu_active | input | 1 | Arithmetic unit busy |
| clr_fifo | input | 1 | Empty the queue and clear overflow |
| rd_req | input | 1 | Host read request |
| rd_ack | output | 1 | Read response valid |
| rd_word | output | 16 | Read response word |
| status_word | output | 16 | Live status word |

## Verification
The hardest states to reach from the ports are those where several events land on the same edge. Examples are a push refused at full depth while a pop frees a slot, a clear that coincides with a push or an overflow, and a read of an empty queue in the same cycle as a push. The bench walks every fill level from zero to one past DEPTH on a depth-4 instance. At each level it drains with one extra read and then clears. Dedicated cycles force the coincident cases. A cycle-accurate model of the queue, the flags and the power-up window checks `in_ready`, the response and the status word on every cycle.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;
  localparam int TAG_W  = 4;
  localparam int RES_W  = 12;
  localparam int WORD_W = TAG_W + RES_W;

  // status bit positions
  localparam int ST_EMPTY = 0;
  localparam int ST_CONV  = 1;
  localparam int ST_ALU   = 2;
  localparam int ST_OVF   = 3;
  localparam int ST_USED  = 4;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [RES_W-1:0] result;
  } conv_entry_t;
endpackage

// File: rtl/tagfifo_mem.sv
module tagfifo_mem
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  conv_entry_t push_entry,
  input  logic        pop,
  input  logic        clr,
  output conv_entry_t head,
  output logic        empty,
  output logic        full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  conv_entry_t   store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_en, rd_en;

  assign empty = (count == '0);
  assign full  = (count == CAP);
  assign wr_en = push && !full && !clr;
  assign rd_en = pop && !empty && !clr;
  assign head  = store[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) store[wptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
endmodule

// File: rtl/pwrup_window.sv
module pwrup_window #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned WIN_US = 134
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam longint unsigned RAW = (longint'(CLK_HZ) * WIN_US + 999_999) / 1_000_000;
  localparam longint unsigned WIN = (RAW == 0) ? 1 : RAW;
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= CW'(WIN);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // R7
  window_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/conv_tag_fifo.sv
module conv_tag_fifo
  import conv_fifo_pkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [RES_W-1:0]  in_result,
  input  logic              conv_active,
  input  logic              alarm_active,
  input  logic              alu_active,
  input  logic              clr_fifo,
  input  logic              rd_req,
  output logic              rd_ack,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] status_word
);
  conv_entry_t head;
  logic        empty, full, win_busy;
  logic        conv_q, alu_q, ovf_q;

  assign in_ready = !full;

  tagfifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (in_valid),
    .push_entry ('{tag: in_tag, result: in_result}),
    .pop        (rd_req),
    .clr        (clr_fifo),
    .head       (head),
    .empty      (empty),
    .full       (full)
  );

  pwrup_window #(.CLK_HZ(CLK_HZ), .WIN_US(134)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (win_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      alu_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      conv_q <= conv_active | alarm_active | in_valid;
      alu_q  <= alu_active;
      if (clr_fifo)              ovf_q <= 1'b0;
      else if (in_valid && full) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[ST_EMPTY] = empty;
    status_word[ST_CONV]  = conv_q;
    status_word[ST_ALU]   = alu_q | win_busy;
    status_word[ST_OVF]   = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_ack <= rd_req;
      if (rd_req) rd_word <= empty ? status_word : WORD_W'(head);
    end
  end

  // R2
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);
  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && status_word[ST_EMPTY]) |=> (rd_word == $past(status_word)));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[ST_OVF] && !clr_fifo) |=> status_word[ST_OVF]);
  // R6
  conv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active || alarm_active) |=> status_word[ST_CONV]);
endmodule

// File: tb/conv_tag_fifo_test.sv
module conv_tag_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int WIN = (134 * CLK_HZ + 999_999) / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, conv_active = 1'b0, alarm_active = 1'b0;
  logic        alu_active = 1'b0, clr_fifo = 1'b0, rd_req = 1'b0;
  logic [3:0]  in_tag = '0;
  logic [11:0] in_result = '0;
  logic        in_ready, rd_ack;
  logic [15:0] rd_word, status_word;

  int checks = 0, errors = 0;
  logic [15:0] mq [DEPTH];
  int  mcount = 0, ncyc = 0;
  logic movf = 0, mconv = 0, malu = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_tag_fifo #(.DEPTH(DEPTH), .CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_result(in_result), .conv_active(conv_active),
    .alarm_active(alarm_active), .alu_active(alu_active), .clr_fifo(clr_fifo),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_word(rd_word), .status_word(status_word)
  );

  function automatic logic [15:0] mstat();
    return {12'h000, movf, (malu || ncyc < WIN), mconv, (mcount == 0)};
  endfunction

  task automatic chk(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [3:0] tg, input logic [11:0] rs,
                     input logic ca, input logic aa, input logic al,
                     input logic cl, input logic rd);
    logic [15:0] pre, expw;
    logic exp_rdy;
    string rq;
    in_valid = v; in_tag = tg; in_result = rs; conv_active = ca;
    alarm_active = aa; alu_active = al; clr_fifo = cl; rd_req = rd;
    #1;
    pre = mstat();
    exp_rdy = (mcount < DEPTH);
    chk(in_ready == exp_rdy, "R1/R10 in_ready", 16'(in_ready), 16'(exp_rdy));
    @(posedge clk);
    rq = (mcount > 0) ? "R2 oldest entry" : "R3 empty read returns status";
    expw = (mcount > 0) ? mq[0] : pre;
    if (cl) begin
      mcount = 0; movf = 0;
    end else begin
      if (rd && mcount > 0) begin
        for (int k = 0; k < DEPTH - 1; k++) mq[k] = mq[k+1];
        mcount--;
      end
      if (v) begin
        if (exp_rdy) begin mq[mcount] = {tg, rs}; mcount++; end
        else movf = 1;
      end
    end
    mconv = ca | aa | v;
    malu  = al;
    ncyc++;
    @(negedge clk);
    chk(rd_ack == rd, "R2 rd_ack", 16'(rd_ack), 16'(rd));
    if (rd) chk(rd_word == expw, rq, rd_word, expw);
    chk(status_word == mstat(), "R4/R5/R6/R7/R8 status_word", status_word, mstat());
    in_valid = 0; conv_active = 0; alarm_active = 0; alu_active = 0;
    clr_fifo = 0; rd_req = 0;
  endtask

  task automatic idle();
    cyc(0, 4'h0, 12'h000, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state (window busy included per R7)
    chk(status_word == 16'h0005, "R9 reset status", status_word, 16'h0005);
    chk(rd_ack == 1'b0, "R9 rd_ack", 16'(rd_ack), 16'h0);
    chk(in_ready == 1'b1, "R9 in_ready", 16'(in_ready), 16'h1);
    // R7 power-up window, tracked cycle by cycle
    for (int i = 0; i < WIN + 3; i++) idle();
    // R1 R2 R3 R5 R10 fill-level sweep, then R8 clear
    for (int lvl = 0; lvl <= DEPTH + 1; lvl++) begin
      for (int i = 0; i < lvl; i++)
        cyc(1, 4'((i * 5 + lvl) & 15), 12'((i * 773 + lvl * 91) & 12'hFFF), 0, 0, 0, 0, 0);
      idle();
      for (int k = 0; k <= lvl; k++) cyc(0, 4'h0, 12'h000, 0, 0, 0, 0, 1);
      cyc(0, 4'h0, 12'h000, 0, 0, 0, 1, 0);
      idle();
    end
    // R8 clear racing a push, with data held
    for (int i = 0; i < 3; i++) cyc(1, 4'(i + 9), 12'(i * 300 + 7), 0, 0, 0, 0, 0);
    cyc(1, 4'hF, 12'hABC, 0, 0, 0, 1, 0);
    idle();
    cyc(0, 4'h0, 12'h000, 0, 0, 0, 0, 1);
    // R8 clear racing an overflowing push
    for (int i = 0; i < DEPTH; i++) cyc(1, 4'(i), 12'(i + 1), 0, 0, 0, 0, 0);
    cyc(1, 4'h7, 12'h777, 0, 0, 0, 1, 0);
    idle();
    // R3 push and empty read in one cycle, then R2 read of the pushed entry
    cyc(1, 4'h6, 12'h5A5, 0, 0, 0, 0, 1);
    cyc(0, 4'h0, 12'h000, 0, 0, 0, 0, 1);
    // R5 full, pop and refused push together
    for (int i = 0; i < DEPTH; i++) cyc(1, 4'(i + 2), 12'(i * 1000), 0, 0, 0, 0, 0);
    cyc(1, 4'hE, 12'h111, 0, 0, 0, 0, 1);
    for (int k = 0; k < DEPTH; k++) cyc(0, 4'h0, 12'h000, 0, 0, 0, 0, 1);
    cyc(0, 4'h0, 12'h000, 0, 0, 0, 1, 0);
    // R6 converter busy sources, R7 arithmetic busy input
    cyc(0, 4'h0, 12'h000, 1, 0, 0, 0, 0);
    cyc(0, 4'h0, 12'h000, 0, 1, 0, 0, 0);
    cyc(0, 4'h0, 12'h000, 1, 1, 1, 0, 0);
    cyc(0, 4'h0, 12'h000, 0, 0, 1, 0, 1);
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule